// File: doc/BRIEF.md
# Dual-Clock FIFO with Run-Time Fill Thresholds

This block passes data words from a write clock domain to an unrelated read clock domain. The write and read positions are held as binary counters. Each counter is one bit wider than the storage address, so a full FIFO and an empty FIFO can be told apart. Each side sends a Gray-coded copy of its counter to the other side through a two-stage synchronizer. Only one bit of that copy changes per step, so a half-captured value is never more than one step off.

Besides the registered full and empty flags, each side has a warning flag with a threshold that can be changed at run time. The write side converts the incoming Gray read position back to binary and subtracts it from its own binary position to get the fill level. It raises almost-full when the free space left is at or below its threshold. The read side does the same subtraction the other way round and raises almost-empty when the fill level is at or below its own threshold. The flags are computed in binary, so they stay correct when the counters wrap.

Because each synchronized copy lags its source, every flag can only err on the safe side. The write side may think the FIFO is fuller than it is, and the read side may think it is emptier. The read port shows the oldest stored word whenever empty is low. A read strobe removes that word.

Top module: `afifo_flags_top`

## Requirements
- R1: After reset, rd_empty and rd_aempty read 1, and wr_full and wr_afull read 0.
- R2: Words leave in the order they were accepted. While rd_empty is 0, rd_data shows the oldest stored word, and rd_en high on a rd_clk edge removes it.
- R3: While wr_full is 1, wr_en is ignored: no word is stored, and the write position does not move.
- R4: While rd_empty is 0 is false (rd_empty is 1), rd_en is ignored: the read position does not move, and no stored word is lost.
- R5: wr_full rises on the wr_clk edge that stores the DEPTH-th word (DEPTH = 32 by default). Once reads have been idle long enough to cross, wr_full equals (stored count == DEPTH). It is never 0 while DEPTH words are stored.
- R6: rd_empty rises on the rd_clk edge that removes the last word. Once writes have been idle long enough to cross, rd_empty equals (stored count == 0). It is never 0 while no word is stored.
- R7: The write side sees fill level L. wr_afull is 1 exactly when L + wr_afull_lvl >= DEPTH. With DEPTH 32 and a threshold of 4, it stays 0 for the first 27 writes into an empty FIFO and rises on the 28th. It is never 0 while the true level is at or above DEPTH - wr_afull_lvl.
- R8: The read side sees fill level L. rd_aempty is 1 exactly when L <= rd_aempty_lvl. It is never 0 while the true level is at or below rd_aempty_lvl.
- R9: The flags of R5 to R8 and the order of R2 hold after both positions have wrapped past 2*DEPTH. Each Gray position sent across changes by at most one bit per edge of its own clock.
- R10: With a threshold of 0, wr_afull behaves exactly like wr_full, and rd_aempty behaves exactly like rd_empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write domain clock |
| wr_rst_n | input | 1 | Write domain reset, active low, asynchronous assert |
| wr_en | input | 1 | Write request |
| wr_data | input | DW | Word to store |
| wr_afull_lvl | input | AW+1 | Free-space threshold for wr_afull |
| wr_full | output | 1 | No free entry (registered, write domain) |
| wr_afull | output | 1 | Free space at or below threshold (registered, write domain) |
| rd_clk | input | 1 | Read domain clock |
| rd_rst_n | input | 1 | Read domain reset, active low, asynchronous assert |
| rd_en | input | 1 | Read request, removes the shown word |
| rd_aempty_lvl | input | AW+1 | Fill-level threshold for rd_aempty |
| rd_data | output | DW | Oldest stored word |
| rd_empty | output | 1 | No stored word (registered, read domain) |
| rd_aempty | output | 1 | Fill level at or below threshold (registered, read domain) |

## Verification
The hardest case to reach from the ports is a threshold decision made just as the counters wrap, while the other domain's copy is still in flight. A fixed fill and drain from reset never gets there. The stimulus first runs thousands of cycles of randomized, unequally weighted traffic on two unrelated clocks, which carries both positions around the counter range many times. During that traffic each flag is checked only in its safe direction against the reference queue. The bench then drains the FIFO and repeats a word-by-word fill and drain from that offset position with zero thresholds, checking each flag exactly after the crossing has settled.

// File: rtl/afifo_pkg.sv
package afifo_pkg;

  // Reflected binary code of a counter value
  function automatic logic [31:0] bin2gray(input logic [31:0] b);
    return b ^ (b >> 1);
  endfunction

  // Prefix XOR from the top bit down; zero-extended inputs convert unchanged
  function automatic logic [31:0] gray2bin(input logic [31:0] g);
    logic [31:0] b;
    b[31] = g[31];
    for (int i = 30; i >= 0; i--) begin
      b[i] = b[i+1] ^ g[i];
    end
    return b;
  endfunction

endpackage

// File: rtl/afifo_sync.sv
module afifo_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg1_q;
  logic [W-1:0] stg2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg1_q <= '0;
      stg2_q <= '0;
    end else begin
      stg1_q <= d;
      stg2_q <= stg1_q;
    end
  end

  assign q = stg2_q;

endmodule

// File: rtl/afifo_mem.sv
module afifo_mem #(
  parameter int DW = 8,
  parameter int AW = 5
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] store_q [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) begin
      store_q[waddr] <= wdata;
    end
  end

  assign rdata = store_q[raddr];

endmodule

// File: rtl/afifo_wr_ctl.sv
module afifo_wr_ctl
  import afifo_pkg::*;
#(
  parameter  int AW = 5,
  localparam int PW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [PW-1:0] thr,
  input  logic [PW-1:0] rgray_s,
  output logic [PW-1:0] wbin,
  output logic [PW-1:0] wgray,
  output logic          full,
  output logic          afull,
  output logic          we,
  output logic [AW-1:0] waddr
);

  localparam int LW    = PW + 1;
  localparam int DEPTH = 1 << AW;

  logic [PW-1:0] wbin_q, wbin_nx;
  logic [PW-1:0] wgray_q, wgray_nx;
  logic          full_q, full_nx;
  logic          afull_q, afull_nx;
  logic          inc;
  logic [PW-1:0] rbin_s;
  logic [PW-1:0] level_nx;

  always_comb begin
    inc      = push & ~full_q;
    wbin_nx  = wbin_q + PW'(inc);
    wgray_nx = PW'(bin2gray(32'(wbin_nx)));
    rbin_s   = PW'(gray2bin(32'(rgray_s)));
    level_nx = wbin_nx - rbin_s;
    full_nx  = (wgray_nx == {~rgray_s[PW-1:PW-2], rgray_s[PW-3:0]});
    afull_nx = ({1'b0, level_nx} + {1'b0, thr}) >= LW'(DEPTH);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wbin_q  <= '0;
      wgray_q <= '0;
      full_q  <= 1'b0;
      afull_q <= 1'b0;
    end else begin
      wbin_q  <= wbin_nx;
      wgray_q <= wgray_nx;
      full_q  <= full_nx;
      afull_q <= afull_nx;
    end
  end

  assign wbin  = wbin_q;
  assign wgray = wgray_q;
  assign full  = full_q;
  assign afull = afull_q;
  assign we    = inc;
  assign waddr = wbin_q[AW-1:0];

endmodule

// File: rtl/afifo_rd_ctl.sv
module afifo_rd_ctl
  import afifo_pkg::*;
#(
  parameter  int AW = 5,
  localparam int PW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pop,
  input  logic [PW-1:0] thr,
  input  logic [PW-1:0] wgray_s,
  output logic [PW-1:0] rbin,
  output logic [PW-1:0] rgray,
  output logic          empty,
  output logic          aempty,
  output logic [AW-1:0] raddr
);

  logic [PW-1:0] rbin_q, rbin_nx;
  logic [PW-1:0] rgray_q, rgray_nx;
  logic          empty_q, empty_nx;
  logic          aempty_q, aempty_nx;
  logic          inc;
  logic [PW-1:0] wbin_s;
  logic [PW-1:0] level_nx;

  always_comb begin
    inc       = pop & ~empty_q;
    rbin_nx   = rbin_q + PW'(inc);
    rgray_nx  = PW'(bin2gray(32'(rbin_nx)));
    wbin_s    = PW'(gray2bin(32'(wgray_s)));
    level_nx  = wbin_s - rbin_nx;
    empty_nx  = (rgray_nx == wgray_s);
    aempty_nx = (level_nx <= thr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rbin_q   <= '0;
      rgray_q  <= '0;
      empty_q  <= 1'b1;
      aempty_q <= 1'b1;
    end else begin
      rbin_q   <= rbin_nx;
      rgray_q  <= rgray_nx;
      empty_q  <= empty_nx;
      aempty_q <= aempty_nx;
    end
  end

  assign rbin   = rbin_q;
  assign rgray  = rgray_q;
  assign empty  = empty_q;
  assign aempty = aempty_q;
  assign raddr  = rbin_q[AW-1:0];

endmodule

// File: rtl/afifo_flags_top.sv
module afifo_flags_top #(
  parameter  int DW = 8,
  parameter  int AW = 5,
  localparam int PW = AW + 1
) (
  input  logic          wr_clk,
  input  logic          wr_rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic [PW-1:0] wr_afull_lvl,
  output logic          wr_full,
  output logic          wr_afull,
  input  logic          rd_clk,
  input  logic          rd_rst_n,
  input  logic          rd_en,
  input  logic [PW-1:0] rd_aempty_lvl,
  output logic [DW-1:0] rd_data,
  output logic          rd_empty,
  output logic          rd_aempty
);

  logic          w_rst_n, r_rst_n;
  logic [PW-1:0] w_ptr, r_ptr;
  logic [PW-1:0] w_gray, r_gray;
  logic [PW-1:0] w_gray_at_r, r_gray_at_w;
  logic          mem_we;
  logic [AW-1:0] mem_waddr, mem_raddr;

  // Reset release aligned to each domain's clock
  afifo_sync #(.W(1)) w_rst_sync_i (
    .clk(wr_clk), .rst_n(wr_rst_n), .d(1'b1), .q(w_rst_n)
  );
  afifo_sync #(.W(1)) r_rst_sync_i (
    .clk(rd_clk), .rst_n(rd_rst_n), .d(1'b1), .q(r_rst_n)
  );

  // Gray positions crossing between the domains
  afifo_sync #(.W(PW)) r2w_sync_i (
    .clk(wr_clk), .rst_n(w_rst_n), .d(r_gray), .q(r_gray_at_w)
  );
  afifo_sync #(.W(PW)) w2r_sync_i (
    .clk(rd_clk), .rst_n(r_rst_n), .d(w_gray), .q(w_gray_at_r)
  );

  afifo_wr_ctl #(.AW(AW)) wr_ctl_i (
    .clk     (wr_clk),
    .rst_n   (w_rst_n),
    .push    (wr_en),
    .thr     (wr_afull_lvl),
    .rgray_s (r_gray_at_w),
    .wbin    (w_ptr),
    .wgray   (w_gray),
    .full    (wr_full),
    .afull   (wr_afull),
    .we      (mem_we),
    .waddr   (mem_waddr)
  );

  afifo_rd_ctl #(.AW(AW)) rd_ctl_i (
    .clk     (rd_clk),
    .rst_n   (r_rst_n),
    .pop     (rd_en),
    .thr     (rd_aempty_lvl),
    .wgray_s (w_gray_at_r),
    .rbin    (r_ptr),
    .rgray   (r_gray),
    .empty   (rd_empty),
    .aempty  (rd_aempty),
    .raddr   (mem_raddr)
  );

  afifo_mem #(.DW(DW), .AW(AW)) mem_i (
    .wclk  (wr_clk),
    .we    (mem_we),
    .waddr (mem_waddr),
    .wdata (wr_data),
    .raddr (mem_raddr),
    .rdata (rd_data)
  );

endmodule

// File: rtl/afifo_flags_chk.sv
module afifo_flags_chk #(
  parameter int PW = 6
) (
  input logic          wr_clk,
  input logic          rd_clk,
  input logic          w_rst_n,
  input logic          r_rst_n,
  input logic          wr_full,
  input logic          wr_afull,
  input logic          rd_empty,
  input logic          rd_aempty,
  input logic [PW-1:0] w_ptr,
  input logic [PW-1:0] r_ptr,
  input logic [PW-1:0] w_gray,
  input logic [PW-1:0] r_gray
);

  // R3
  no_overflow_chk: assert property (@(posedge wr_clk) disable iff (!w_rst_n)
    wr_full |=> (w_ptr == $past(w_ptr)));

  // R4
  no_underflow_chk: assert property (@(posedge rd_clk) disable iff (!r_rst_n)
    rd_empty |=> (r_ptr == $past(r_ptr)));

  // R5
  full_implies_afull_chk: assert property (@(posedge wr_clk) disable iff (!w_rst_n)
    wr_full |-> wr_afull);

  // R6
  empty_implies_aempty_chk: assert property (@(posedge rd_clk) disable iff (!r_rst_n)
    rd_empty |-> rd_aempty);

  // R9
  w_gray_step_chk: assert property (@(posedge wr_clk) disable iff (!w_rst_n)
    $countones(w_gray ^ $past(w_gray)) <= 1);

  // R9
  r_gray_step_chk: assert property (@(posedge rd_clk) disable iff (!r_rst_n)
    $countones(r_gray ^ $past(r_gray)) <= 1);

endmodule

bind afifo_flags_top afifo_flags_chk #(.PW(PW)) chk_i (
  .wr_clk    (wr_clk),
  .rd_clk    (rd_clk),
  .w_rst_n   (w_rst_n),
  .r_rst_n   (r_rst_n),
  .wr_full   (wr_full),
  .wr_afull  (wr_afull),
  .rd_empty  (rd_empty),
  .rd_aempty (rd_aempty),
  .w_ptr     (w_ptr),
  .r_ptr     (r_ptr),
  .w_gray    (w_gray),
  .r_gray    (r_gray)
);

// File: tb/afifo_flags_top_tb_top.sv
`timescale 1ns/1ps
module afifo_flags_top_tb_top;

  localparam int DW    = 8;
  localparam int AW    = 5;
  localparam int PW    = AW + 1;
  localparam int DEPTH = 1 << AW;

  logic          wr_clk = 1'b0;
  logic          rd_clk = 1'b0;
  logic          wr_rst_n, rd_rst_n;
  logic          wr_en, rd_en;
  logic [DW-1:0] wr_data;
  logic [PW-1:0] wr_afull_lvl, rd_aempty_lvl;
  logic          wr_full, wr_afull, rd_empty, rd_aempty;
  logic [DW-1:0] rd_data;

  int unsigned vectors = 0;
  int unsigned errors  = 0;

  logic [DW-1:0] model_q[$];
  logic [DW-1:0] wseq = '0;
  int wr_budget = 0, rd_budget = 0;
  int wr_rate = 0, rd_rate = 0;
  bit chk_on = 1'b0;

  always #2.5  wr_clk = ~wr_clk;
  always #3.55 rd_clk = ~rd_clk;

  afifo_flags_top #(.DW(DW), .AW(AW)) dut_i (
    .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .wr_afull_lvl(wr_afull_lvl), .wr_full(wr_full), .wr_afull(wr_afull),
    .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .rd_en(rd_en),
    .rd_aempty_lvl(rd_aempty_lvl), .rd_data(rd_data),
    .rd_empty(rd_empty), .rd_aempty(rd_aempty)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
  endtask

  // Write-side driver: safe-direction flag checks, then stimulus
  always @(negedge wr_clk) begin
    if (chk_on) begin
      // R5: below full whenever the flag is low
      if (!wr_full) chk(model_q.size() < DEPTH, "R5", model_q.size(), DEPTH - 1);
      // R7: the true level must be below the threshold whenever the flag is low
      if (!wr_afull)
        chk(model_q.size() < DEPTH - int'(wr_afull_lvl), "R7",
            model_q.size(), DEPTH - int'(wr_afull_lvl) - 1);
    end
    if (wr_budget > 0 && $urandom_range(99) < wr_rate) begin
      wr_en   = 1'b1;
      wr_data = wseq;
      if (!wr_full) begin
        model_q.push_back(wseq);
        wseq = wseq + 1'b1;
        // R3: storage never exceeds its depth
        chk(model_q.size() <= DEPTH, "R3", model_q.size(), DEPTH);
      end
      wr_budget--;
    end else begin
      wr_en = 1'b0;
    end
  end

  // Read-side monitor: pops the scoreboard and compares data
  always @(negedge rd_clk) begin
    if (chk_on) begin
      // R6 / R4: a word must really be stored when empty is low
      if (!rd_empty) chk(model_q.size() > 0, "R6", model_q.size(), 1);
      // R8: the true level must be above the threshold whenever the flag is low
      if (!rd_aempty)
        chk(model_q.size() > int'(rd_aempty_lvl), "R8",
            model_q.size(), int'(rd_aempty_lvl) + 1);
    end
    if (rd_budget > 0 && $urandom_range(99) < rd_rate) begin
      rd_en = 1'b1;
      if (!rd_empty) begin
        if (model_q.size() == 0) begin
          chk(1'b0, "R4", 0, 1);
        end else begin
          logic [DW-1:0] exp_w;
          exp_w = model_q.pop_front();
          // R2: order of words
          chk(rd_data == exp_w, "R2", rd_data, exp_w);
        end
      end
      rd_budget--;
    end else begin
      rd_en = 1'b0;
    end
  end

  task automatic settle();
    repeat (10) @(posedge rd_clk);
    repeat (10) @(posedge wr_clk);
  endtask

  // Exact flag values once the crossings are quiet
  task automatic static_chk(input string rf, input string re, input string rt);
    @(negedge wr_clk);
    chk(wr_full == (model_q.size() == DEPTH), rf, wr_full, model_q.size() == DEPTH);
    chk(wr_afull == (model_q.size() >= DEPTH - int'(wr_afull_lvl)), rt,
        wr_afull, model_q.size() >= DEPTH - int'(wr_afull_lvl));
    @(negedge rd_clk);
    chk(rd_empty == (model_q.size() == 0), re, rd_empty, model_q.size() == 0);
    chk(rd_aempty == (model_q.size() <= int'(rd_aempty_lvl)), rt,
        rd_aempty, model_q.size() <= int'(rd_aempty_lvl));
  endtask

  task automatic one_write();
    wr_rate = 100; wr_budget = 1;
    wait (wr_budget == 0);
    @(posedge wr_clk);
    settle();
  endtask

  task automatic one_read();
    rd_rate = 100; rd_budget = 1;
    wait (rd_budget == 0);
    @(posedge rd_clk);
    settle();
  endtask

  task automatic set_thr(input int af, input int ae);
    chk_on = 1'b0;
    @(negedge wr_clk);
    wr_afull_lvl  = PW'(af);
    rd_aempty_lvl = PW'(ae);
    settle();
    chk_on = 1'b1;
  endtask

  // Word-by-word fill and drain with exact checks after each step
  task automatic fill_drain(input string rf, input string re, input string rt);
    for (int k = 0; k < DEPTH; k++) begin
      one_write();
      static_chk(rf, re, rt);
    end
    // R3: extra writes while full are ignored
    for (int k = 0; k < 3; k++) one_write();
    @(negedge wr_clk);
    chk(wr_full == 1'b1, "R3", wr_full, 1);
    chk(model_q.size() == DEPTH, "R3", model_q.size(), DEPTH);
    for (int k = 0; k < DEPTH; k++) begin
      one_read();
      static_chk(rf, re, rt);
    end
    // R4: extra reads while empty are ignored
    for (int k = 0; k < 3; k++) one_read();
    @(negedge rd_clk);
    chk(rd_empty == 1'b1, "R4", rd_empty, 1);
  endtask

  initial begin
    wr_en = 1'b0; rd_en = 1'b0; wr_data = '0;
    wr_afull_lvl = PW'(4); rd_aempty_lvl = PW'(3);
    wr_rst_n = 1'b0; rd_rst_n = 1'b0;
    repeat (4) @(posedge wr_clk);
    repeat (4) @(posedge rd_clk);
    @(negedge wr_clk);
    // R1: reset values
    chk(wr_full == 1'b0,  "R1", wr_full, 0);
    chk(wr_afull == 1'b0, "R1", wr_afull, 0);
    chk(rd_empty == 1'b1, "R1", rd_empty, 1);
    chk(rd_aempty == 1'b1, "R1", rd_aempty, 1);
    wr_rst_n = 1'b1; rd_rst_n = 1'b1;
    settle();
    chk_on = 1'b1;

    // R7 / R8: default thresholds, fill from empty and drain
    fill_drain("R5", "R6", "R7");

    // R9: unequal random traffic, many wraps of both positions
    set_thr(6, 5);
    wr_rate = 70; rd_rate = 50; wr_budget = 3000; rd_budget = 3000;
    wait (wr_budget == 0);
    wr_rate = 40; rd_rate = 85; wr_budget = 3000; rd_budget = 4000;
    wait (wr_budget == 0 && rd_budget == 0);
    settle();
    rd_rate = 100; rd_budget = model_q.size() + 4;
    wait (rd_budget == 0);
    settle();
    static_chk("R9", "R9", "R8");

    // R10: zero thresholds from the wrapped position
    set_thr(0, 0);
    fill_drain("R9", "R9", "R10");

    settle();
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge wr_clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    summary();
    $finish;
  end

endmodule